// File: doc/BRIEF.md
# Sixteen-Source Priority Interrupt Controller

The block collects one-cycle event pulses from sixteen sources and turns them into a single active-low interrupt request. Each source owns a channel built from four bits of state: an enable, a pending latch, a mask and an in-service latch. Priority among the channels is fixed, and the channel with the larger index always wins. Software can poll the pending bits through a byte-wide register port. It can also let the processor run a vectored acknowledge. In that acknowledge the controller hands back an 8-bit vector: four programmable high bits, then the winning channel number.

Several controllers can share one acknowledge line. They pass a chain enable from the higher-priority part to the lower-priority part. A controller that has something to serve answers the acknowledge and keeps the chain closed. One that has nothing to serve opens the chain downstream. A mode bit selects automatic end-of-interrupt or software end-of-interrupt. In software end-of-interrupt, a served channel stays marked in service until software clears it. While it is marked, that channel and every channel below it are held off.

Top module: `vic16_ctrl`

## Requirements
- R1: After reset, every register reads 0x00, `irq_n_o` is 1, `dack_o` is 0 and `vec_o` is 0x00.
- R2: An event pulse sets the channel's pending bit at the next clock edge, but only if the channel is enabled after that cycle's register write. Clearing an enable bit also clears that channel's pending bit.
- R3: A write to a pending or in-service byte can only clear bits. A 0 clears the bit and a 1 leaves it unchanged. An event that arrives in the same cycle as a clear of the same channel leaves the pending bit set.
- R4: A channel whose mask bit is 0 still latches events into its pending bit but does not request. Setting the mask bit again restores the request of a channel that is still pending.
- R5: `irq_n_o` is 0 exactly when some channel is pending, unmasked and not blocked, and `ack_n_i` is 1.
- R6: The winning channel is the eligible channel with the highest index. The vector is {vector register bits 7:4, 4-bit channel index}.
- R7: The winner is frozen at the first clock edge at which `ack_n_i` is 0. The vector is passed at a later edge at which `ack_n_i` and `chain_in_n_i` are both 0. From that edge until `ack_n_i` returns to 1, `dack_o` is 1 and `vec_o` holds the vector. At all other times `vec_o` is 0x00. Passing the vector clears the winner's pending bit.
- R8: With vector-register bit 3 at 0 (automatic end-of-interrupt), all in-service bits read 0 and passing a vector sets none of them.
- R9: With vector-register bit 3 at 1 (software end-of-interrupt), passing a vector also sets the channel's in-service bit. Channels at or below the highest in-service index may latch pending bits, but they can neither request nor be passed. Higher channels are served normally.
- R10: `chain_out_n_o` is 0 only when `chain_in_n_i` is 0 and the controller has nothing to serve. "Nothing to serve" means no live request, or, once the winner is frozen, no frozen winner.
- R11: Register map on `reg_addr_i`: 0/1 enable high/low byte, 2/3 pending high/low, 4/5 in-service high/low, 6/7 mask high/low, 8 vector register. The high byte holds channels 15..8 and the low byte holds channels 7..0. The vector register stores bits 7:3 and reads bits 2:0 as 0. Other addresses read 0x00.
- R12: Clearing an enable bit leaves that channel's in-service bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 16 | One-cycle event pulses, bit n for channel n |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| ack_n_i | input | 1 | Acknowledge, active low |
| chain_in_n_i | input | 1 | Chain enable from the higher-priority device, active low |
| chain_out_n_o | output | 1 | Chain enable to the lower-priority device, active low |
| irq_n_o | output | 1 | Interrupt request, active low |
| dack_o | output | 1 | Vector valid / data acknowledge |
| vec_o | output | 8 | Interrupt vector |

## Verification
The delicate coincidence is an event landing on a channel in the same cycle that its pending bit is being cleared, whether the clear comes from a register write or from passing the vector. The bench drives the event pulse and the clearing write into the same cycle and expects the pending bit to survive. It also raises a higher-priority event just after the winner is frozen and expects the vector already chosen to be kept. A behavioural reference model, stepped every clock, judges every output and every register read.

// File: rtl/vic16_pkg.sv
`timescale 1ns/1ps
// Shared constants for the sixteen-channel interrupt controller.
// Assumes a byte-wide register port; channel count is tied to two bytes.
package vic16_pkg;
    localparam int NCH      = 16;
    localparam int IDXW     = $clog2(NCH);
    localparam int BYTEW    = 8;
    localparam int ADRW     = 4;
    localparam int SOFT_BIT = 3;

    localparam logic [ADRW-1:0] ADR_EN_HI   = 4'h0;
    localparam logic [ADRW-1:0] ADR_EN_LO   = 4'h1;
    localparam logic [ADRW-1:0] ADR_PND_HI  = 4'h2;
    localparam logic [ADRW-1:0] ADR_PND_LO  = 4'h3;
    localparam logic [ADRW-1:0] ADR_SRV_HI  = 4'h4;
    localparam logic [ADRW-1:0] ADR_SRV_LO  = 4'h5;
    localparam logic [ADRW-1:0] ADR_MSK_HI  = 4'h6;
    localparam logic [ADRW-1:0] ADR_MSK_LO  = 4'h7;
    localparam logic [ADRW-1:0] ADR_VEC     = 4'h8;
endpackage

// File: rtl/vic16_prio.sv
`timescale 1ns/1ps
// Fixed-priority resolver: the highest-index channel that is pending,
// unmasked and not at/below an in-service channel wins.
// Assumes isr is all zero in automatic end-of-interrupt mode.
module vic16_prio #(
    parameter int NCH  = 16,
    parameter int IDXW = $clog2(NCH)
) (
    input  logic [NCH-1:0]  pend_i,
    input  logic [NCH-1:0]  mask_i,
    input  logic [NCH-1:0]  isr_i,
    output logic            req_o,
    output logic [IDXW-1:0] idx_o
);
    logic [NCH-1:0] blk;
    logic [NCH-1:0] elig;

    // blocking chain: a channel is held off by any in-service bit at or above it
    assign blk[NCH-1] = isr_i[NCH-1];
    for (genvar g = NCH - 2; g >= 0; g--) begin : g_blk
        assign blk[g] = blk[g+1] | isr_i[g];
    end

    assign elig  = pend_i & mask_i & ~blk;
    assign req_o = |elig;

    // encoder: later (higher) indices overwrite earlier ones
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < NCH; i++) begin
            if (elig[i]) idx_o = IDXW'(i);
        end
    end
endmodule

// File: rtl/vic16_ack.sv
`timescale 1ns/1ps
// Acknowledge sequencer: freezes the winner on the first acknowledge edge,
// passes the vector once the chain enable is low, holds it until release.
// Assumes ack_n_i and chain_in_n_i are synchronous to clk.
module vic16_ack #(
    parameter int IDXW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ack_n_i,
    input  logic            chain_in_n_i,
    input  logic            live_req_i,
    input  logic [IDXW-1:0] live_idx_i,
    output logic            pass_o,
    output logic [IDXW-1:0] frz_idx_o,
    output logic            dack_o,
    output logic            have_o
);
    logic ack_q;
    logic frz_v;
    logic done;
    logic frozen;

    assign frozen = ~ack_n_i & ~ack_q;
    assign pass_o = frozen & ~chain_in_n_i & frz_v & ~done;
    assign dack_o = done & ~ack_n_i;
    assign have_o = frozen ? frz_v : live_req_i;

    // sequence state: capture on entry, mark done on pass, drop on release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q     <= 1'b1;
            frz_v     <= 1'b0;
            frz_idx_o <= '0;
            done      <= 1'b0;
        end else begin
            ack_q <= ack_n_i;
            if (ack_n_i) begin
                frz_v <= 1'b0;
                done  <= 1'b0;
            end else if (ack_q) begin
                frz_v     <= live_req_i;
                frz_idx_o <= live_idx_i;
            end else if (pass_o) begin
                done <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/vic16_bank.sv
`timescale 1ns/1ps
// Channel state bank: enable, pending, mask, in-service and vector register,
// with clear-only writes to pending and in-service.
// Assumes at most one register write per cycle.
module vic16_bank
    import vic16_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   evt_i,
    input  logic             wr_i,
    input  logic [ADRW-1:0]  addr_i,
    input  logic [BYTEW-1:0] wdata_i,
    input  logic             pass_i,
    input  logic [IDXW-1:0]  pass_idx_i,
    output logic [NCH-1:0]   en_o,
    output logic [NCH-1:0]   pend_o,
    output logic [NCH-1:0]   mask_o,
    output logic [NCH-1:0]   isr_o,
    output logic [BYTEW-1:0] vr_o
);
    logic [NCH-1:0]   en_n, pend_n, mask_n, isr_n;
    logic [NCH-1:0]   pclr, iclr, pass_oh;
    logic [BYTEW-1:0] vr_n;

    // next-state: register writes, events, vector pass
    always_comb begin
        en_n    = en_o;
        mask_n  = mask_o;
        vr_n    = vr_o;
        pclr    = '1;
        iclr    = '1;
        pass_oh = '0;
        if (pass_i) pass_oh[pass_idx_i] = 1'b1;
        if (wr_i) begin
            case (addr_i)
                ADR_EN_HI:  en_n[NCH-1:BYTEW]   = wdata_i;
                ADR_EN_LO:  en_n[BYTEW-1:0]     = wdata_i;
                ADR_PND_HI: pclr[NCH-1:BYTEW]   = wdata_i;
                ADR_PND_LO: pclr[BYTEW-1:0]     = wdata_i;
                ADR_SRV_HI: iclr[NCH-1:BYTEW]   = wdata_i;
                ADR_SRV_LO: iclr[BYTEW-1:0]     = wdata_i;
                ADR_MSK_HI: mask_n[NCH-1:BYTEW] = wdata_i;
                ADR_MSK_LO: mask_n[BYTEW-1:0]   = wdata_i;
                ADR_VEC:    vr_n = {wdata_i[BYTEW-1:SOFT_BIT], {SOFT_BIT{1'b0}}};
                default:    ;
            endcase
        end
        pend_n = ((pend_o & pclr & ~pass_oh) | evt_i) & en_n;
        isr_n  = vr_n[SOFT_BIT] ? ((isr_o & iclr) | pass_oh) : '0;
    end

    // state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o   <= '0;
            pend_o <= '0;
            mask_o <= '0;
            isr_o  <= '0;
            vr_o   <= '0;
        end else begin
            en_o   <= en_n;
            pend_o <= pend_n;
            mask_o <= mask_n;
            isr_o  <= isr_n;
            vr_o   <= vr_n;
        end
    end
endmodule

// File: rtl/vic16_ctrl.sv
`timescale 1ns/1ps
// Top of the sixteen-channel prioritized vectored interrupt controller.
// Ties the state bank, resolver and acknowledge sequencer together and
// produces the request, chain and vector outputs plus register readback.
// Assumes register accesses and acknowledge do not overlap on the bus.
module vic16_ctrl
    import vic16_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   evt_i,
    input  logic             reg_wr_i,
    input  logic [ADRW-1:0]  reg_addr_i,
    input  logic [BYTEW-1:0] reg_wdata_i,
    output logic [BYTEW-1:0] reg_rdata_o,
    input  logic             ack_n_i,
    input  logic             chain_in_n_i,
    output logic             chain_out_n_o,
    output logic             irq_n_o,
    output logic             dack_o,
    output logic [BYTEW-1:0] vec_o
);
    logic [NCH-1:0]   en_q, pend_q, mask_q, isr_q;
    logic [BYTEW-1:0] vr_q;
    logic             req;
    logic [IDXW-1:0]  win_idx, frz_idx;
    logic             pass, have;

    vic16_bank i_bank (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
        .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
        .pass_i(pass), .pass_idx_i(frz_idx),
        .en_o(en_q), .pend_o(pend_q), .mask_o(mask_q), .isr_o(isr_q), .vr_o(vr_q)
    );

    vic16_prio #(.NCH(NCH), .IDXW(IDXW)) i_prio (
        .pend_i(pend_q), .mask_i(mask_q), .isr_i(isr_q),
        .req_o(req), .idx_o(win_idx)
    );

    vic16_ack #(.IDXW(IDXW)) i_ack (
        .clk(clk), .rst_n(rst_n), .ack_n_i(ack_n_i), .chain_in_n_i(chain_in_n_i),
        .live_req_i(req), .live_idx_i(win_idx),
        .pass_o(pass), .frz_idx_o(frz_idx), .dack_o(dack_o), .have_o(have)
    );

    assign irq_n_o       = ~(req & ack_n_i);
    assign chain_out_n_o = chain_in_n_i | have;
    assign vec_o         = dack_o ? {vr_q[BYTEW-1:IDXW], frz_idx} : '0;

    // register readback mux
    always_comb begin
        case (reg_addr_i)
            ADR_EN_HI:  reg_rdata_o = en_q[NCH-1:BYTEW];
            ADR_EN_LO:  reg_rdata_o = en_q[BYTEW-1:0];
            ADR_PND_HI: reg_rdata_o = pend_q[NCH-1:BYTEW];
            ADR_PND_LO: reg_rdata_o = pend_q[BYTEW-1:0];
            ADR_SRV_HI: reg_rdata_o = isr_q[NCH-1:BYTEW];
            ADR_SRV_LO: reg_rdata_o = isr_q[BYTEW-1:0];
            ADR_MSK_HI: reg_rdata_o = mask_q[NCH-1:BYTEW];
            ADR_MSK_LO: reg_rdata_o = mask_q[BYTEW-1:0];
            ADR_VEC:    reg_rdata_o = vr_q;
            default:    reg_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/vic16_chk.sv
`timescale 1ns/1ps
// Property checker for vic16_ctrl, attached by bind.
// Assumes it sees the top's ports and its channel state vectors.
module vic16_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ack_n_i,
    input logic        chain_in_n_i,
    input logic        chain_out_n_o,
    input logic        irq_n_o,
    input logic        dack_o,
    input logic [7:0]  vec_o,
    input logic [15:0] en_q,
    input logic [15:0] pend_q,
    input logic [15:0] isr_q,
    input logic [7:0]  vr_q
);
    // R7
    dack_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dack_o |-> !ack_n_i);

    // R7
    vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dack_o && $past(dack_o)) |-> $stable(vec_o));

    // R2
    disabled_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q & ~en_q) == 16'h0000);

    // R8
    auto_isr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vr_q[3] |-> (isr_q == 16'h0000));

    // R10
    chain_need_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chain_out_n_o |-> !chain_in_n_i);

    // R10
    chain_closed_serving_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dack_o |-> chain_out_n_o);

    // R5
    irq_quiet_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n_i |-> irq_n_o);
endmodule

bind vic16_ctrl vic16_chk i_chk (
    .clk(clk), .rst_n(rst_n), .ack_n_i(ack_n_i), .chain_in_n_i(chain_in_n_i),
    .chain_out_n_o(chain_out_n_o), .irq_n_o(irq_n_o), .dack_o(dack_o),
    .vec_o(vec_o), .en_q(en_q), .pend_q(pend_q), .isr_q(isr_q), .vr_q(vr_q)
);

// File: tb/test_vic16_ctrl.sv
`timescale 1ns/1ps
// Self-checking bench: behavioural reference model stepped every clock,
// plus directed scenarios with literal expectations.
module test_vic16_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] evt = '0;
    logic        wr = 1'b0;
    logic [3:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        ack_n = 1'b1;
    logic        chin_n = 1'b1;
    logic        chout_n, irq_n, dack;
    logic [7:0]  vec;
    int          checks = 0;
    int          errors = 0;

    always #4 clk = ~clk;

    vic16_ctrl i_vic16_ctrl (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .reg_wr_i(wr), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ack_n_i(ack_n),
        .chain_in_n_i(chin_n), .chain_out_n_o(chout_n), .irq_n_o(irq_n),
        .dack_o(dack), .vec_o(vec)
    );

    // ---------------- reference model ----------------
    bit [15:0] m_en, m_pend, m_mask, m_isr;
    bit [7:0]  m_vr;
    bit        m_ackq = 1'b1, m_fv, m_done;
    int        m_fi;

    function automatic int m_win();
        for (int i = 15; i >= 0; i--) begin
            if (m_isr[i]) return -1;
            if (m_pend[i] && m_mask[i]) return i;
        end
        return -1;
    endfunction

    function automatic bit [7:0] m_read(input bit [3:0] a);
        case (a)
            0: return m_en[15:8];   1: return m_en[7:0];
            2: return m_pend[15:8]; 3: return m_pend[7:0];
            4: return m_isr[15:8];  5: return m_isr[7:0];
            6: return m_mask[15:8]; 7: return m_mask[7:0];
            8: return m_vr;
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_pend = 0; m_mask = 0; m_isr = 0; m_vr = 0;
            m_ackq = 1; m_fv = 0; m_done = 0; m_fi = 0;
        end else begin
            int  w;
            bit  pass;
            bit [15:0] en2, p, s;
            bit [7:0]  vr2;
            w    = m_win();
            pass = !ack_n && !m_ackq && !chin_n && m_fv && !m_done;
            en2 = m_en; vr2 = m_vr; p = m_pend; s = m_isr;
            if (wr) begin
                case (addr)
                    0: en2[15:8] = wdata;     1: en2[7:0] = wdata;
                    2: p[15:8] &= wdata;      3: p[7:0] &= wdata;
                    4: s[15:8] &= wdata;      5: s[7:0] &= wdata;
                    6: m_mask[15:8] = wdata;  7: m_mask[7:0] = wdata;
                    8: vr2 = wdata & 8'hF8;
                    default: ;
                endcase
            end
            if (pass) begin
                p[m_fi] = 1'b0;
                s[m_fi] = 1'b1;
            end
            p = (p | evt) & en2;
            if (!vr2[3]) s = 0;
            m_en = en2; m_vr = vr2; m_pend = p; m_isr = s;
            if (ack_n) begin
                m_fv = 0; m_done = 0;
            end else if (m_ackq) begin
                m_fv = (w >= 0);
                m_fi = (w >= 0) ? w : 0;
            end else if (pass) begin
                m_done = 1;
            end
            m_ackq = ack_n;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model, after the edge settles
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            bit        frozen, have, e_dack;
            bit [7:0]  e_vec;
            frozen = !ack_n && !m_ackq;
            have   = frozen ? m_fv : (m_win() >= 0);
            e_dack = m_done && !ack_n;
            e_vec  = e_dack ? {m_vr[7:4], 4'(m_fi)} : 8'h00;
            chk("R5 model irq_n", {15'd0, irq_n}, {15'd0, !((m_win() >= 0) && ack_n)});
            chk("R7 model dack", {15'd0, dack}, {15'd0, e_dack});
            chk("R6 model vec", {8'd0, vec}, {8'd0, e_vec});
            chk("R10 model chain_out", {15'd0, chout_n}, {15'd0, chin_n || have});
            chk("R11 model readback", {8'd0, rdata}, {8'd0, m_read(addr)});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wreg(input bit [3:0] a, input bit [7:0] d);
        @(negedge clk); wr = 1; addr = a; wdata = d;
        @(negedge clk); wr = 0;
    endtask

    task automatic pulse(input bit [15:0] m);
        @(negedge clk); evt = m;
        @(negedge clk); evt = 0;
    endtask

    task automatic rchk(input string tag, input bit [3:0] a, input bit [7:0] e);
        @(negedge clk); addr = a; #1;
        chk(tag, {8'd0, rdata}, {8'd0, e});
    endtask

    task automatic ack_seq(input bit ci, output bit [7:0] v, output bit d);
        @(negedge clk); ack_n = 0; chin_n = ci;
        @(posedge clk); @(posedge clk); #2;
        v = vec; d = dack;
        chk("R5 irq high during ack", {15'd0, irq_n}, 16'd1);
        @(negedge clk); ack_n = 1; chin_n = 1;
    endtask

    // ---------------- directed scenarios ----------------
    initial begin
        bit [7:0] v;
        bit       d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        chk("R1 irq_n", {15'd0, irq_n}, 16'd1);
        chk("R1 dack", {15'd0, dack}, 16'd0);
        chk("R1 vec", {8'd0, vec}, 16'd0);
        rchk("R1 enable low", 4'h1, 8'h00);
        rchk("R1 vector reg", 4'h8, 8'h00);

        wreg(0, 8'hFF); wreg(1, 8'hFF); wreg(6, 8'hFF); wreg(7, 8'hFF);
        // R11 vector register low bits read zero
        wreg(8, 8'h47);
        rchk("R11 vr low bits", 4'h8, 8'h40);
        rchk("R11 unmapped", 4'hF, 8'h00);

        // R2 event sets pending; disabling clears
        pulse(16'h0008);
        rchk("R2 pending set", 4'h3, 8'h08);
        #1 chk("R5 irq asserted", {15'd0, irq_n}, 16'd0);
        wreg(1, 8'h00);
        rchk("R2 disable clears", 4'h3, 8'h00);
        pulse(16'h0004);
        rchk("R2 disabled ignored", 4'h3, 8'h00);
        wreg(1, 8'hFF);

        // R3 clear-only write
        pulse(16'h0024);
        wreg(3, 8'hDF);
        rchk("R3 single clear", 4'h3, 8'h04);
        wreg(3, 8'hFF);
        rchk("R3 ones keep", 4'h3, 8'h04);
        // R3 event in the same cycle as a clear survives
        @(negedge clk); wr = 1; addr = 3; wdata = 8'hFB; evt = 16'h0004;
        @(negedge clk); wr = 0; evt = 0;
        rchk("R3 event beats clear", 4'h3, 8'h04);

        // R4 mask
        wreg(7, 8'h00);
        #1 chk("R4 masked no irq", {15'd0, irq_n}, 16'd1);
        pulse(16'h0001);
        rchk("R4 masked still latches", 4'h3, 8'h05);
        wreg(7, 8'hFF);
        #1 chk("R4 unmask resumes", {15'd0, irq_n}, 16'd0);

        // R6 R7 vectored acknowledge, automatic mode
        ack_seq(0, v, d);
        chk("R7 dack", {15'd0, d}, 16'd1);
        chk("R6 vec ch2", {8'd0, v}, 16'h0042);
        ack_seq(0, v, d);
        chk("R6 vec ch0", {8'd0, v}, 16'h0040);
        rchk("R7 pass clears pending", 4'h3, 8'h00);
        rchk("R8 no in-service in auto", 4'h5, 8'h00);
        pulse(16'h4002);
        ack_seq(0, v, d);
        chk("R6 highest wins", {8'd0, v}, 16'h004E);
        ack_seq(0, v, d);
        chk("R6 next lower", {8'd0, v}, 16'h0041);

        // R9 software end-of-interrupt
        wreg(8, 8'h48);
        rchk("R11 vr soft", 4'h8, 8'h48);
        pulse(16'h0200);
        ack_seq(0, v, d);
        chk("R9 vec ch9", {8'd0, v}, 16'h0049);
        rchk("R9 in-service set", 4'h4, 8'h02);
        pulse(16'h0010);
        #1 chk("R9 lower blocked", {15'd0, irq_n}, 16'd1);
        rchk("R9 lower still latches", 4'h3, 8'h10);
        pulse(16'h1000);
        #1 chk("R9 higher requests", {15'd0, irq_n}, 16'd0);
        ack_seq(0, v, d);
        chk("R9 vec ch12", {8'd0, v}, 16'h004C);
        rchk("R9 nested in-service", 4'h4, 8'h12);
        wreg(4, 8'hEF);
        rchk("R3 in-service clear", 4'h4, 8'h02);
        #1 chk("R9 still blocked", {15'd0, irq_n}, 16'd1);
        wreg(4, 8'hFD);
        #1 chk("R9 unblocked", {15'd0, irq_n}, 16'd0);
        ack_seq(0, v, d);
        chk("R9 vec ch4", {8'd0, v}, 16'h0044);
        wreg(1, 8'h00);
        rchk("R12 disable keeps in-service", 4'h5, 8'h10);
        wreg(1, 8'hFF);
        wreg(8, 8'h40);
        rchk("R8 auto clears in-service", 4'h5, 8'h00);

        // R7 R10 chain behaviour
        pulse(16'h0040);
        ack_seq(1, v, d);
        chk("R7 no pass without chain", {15'd0, d}, 16'd0);
        rchk("R7 pending kept", 4'h3, 8'h40);
        @(negedge clk); chin_n = 0; #1;
        chk("R10 chain closed with work", {15'd0, chout_n}, 16'd1);
        // R7 freeze: higher event after capture does not alter vector
        @(negedge clk); ack_n = 0;
        @(negedge clk); evt = 16'h8000;
        @(negedge clk); evt = 0; #1;
        chk("R7 frozen vec", {8'd0, vec}, 16'h0046);
        @(negedge clk); ack_n = 1;
        ack_seq(0, v, d);
        chk("R7 later ch15", {8'd0, v}, 16'h004F);
        @(negedge clk); chin_n = 0; #1;
        chk("R10 chain open idle", {15'd0, chout_n}, 16'd0);
        ack_seq(0, v, d);
        chk("R10 idle no dack", {15'd0, d}, 16'd0);

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // watchdog
    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule